// File: doc/BRIEF.md
# Explicit-parallel bundle issue unit

This unit sits between an instruction fetch buffer and a set of typed execution ports. It takes in 128-bit bundles, each holding three 41-bit operations and a 5-bit template. The template tells the unit which functional-unit class each slot belongs to: memory/address update, integer, floating point or branch. It also marks where the compiler placed group boundaries ("stops"). The hardware trusts those boundaries. It does no dependence checking. Each cycle it issues the whole of the next group to its ports, or nothing at all.

The window holds two bundles, so a group that runs across a bundle edge issues in a single cycle. A bundle whose template code is not in the supported set is dropped when it is accepted, and an error pulse is raised. Each class has `NPORT` ports. The k-th operation of a class within a group goes to port k of that class.

Top module: `bundle_issue`

## Requirements
- R1: The template sits in bits [4:0]. Slot s occupies bits [5+41s +: 41]. Template bits [4:2] select the slot classes, in slot order 0,1,2: 0=M,I,I; 1=M,M,I; 2=M,F,I; 3=M,M,F; 4=M,I,B; 5=M,B,B. Template bits [1:0] select the stops: 0 = no stop; 1 = stop after slot 2; 2 = stops after slots 0 and 2; 3 = stops after slots 1 and 2. Codes 24 to 31 are illegal.
- R2: An accepted bundle with an illegal template is not stored and issues nothing. `err_o` is high for exactly the cycle after such a bundle is accepted.
- R3: A group runs from the oldest unissued slot up to and including the first slot that carries a stop. All non-no-op operations of the group have their port valid in the same cycle.
- R4: If no stop is reached before the end of the older bundle, the group continues into the next bundle. While that next bundle is absent, nothing issues. A group always ends at the last slot of the second bundle.
- R5: A slot whose 41-bit field is all zero is a no-op. It asserts no port.
- R6: The k-th non-no-op operation of a class within a group, counted in slot order, drives port k of that class. The port payload equals the slot field.
- R7: A group issues only when every port it needs is ready. Otherwise no port of any class is valid, and issue order is kept.
- R8: The window holds at most two bundles. `in_ready` is high exactly when fewer than two bundles are held.
- R9: After reset all port valids and `err_o` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Bundle offered by the fetch buffer |
| in_bundle | input | 128 | Bundle: template and three slots |
| in_ready | output | 1 | Window can accept a bundle |
| err_o | output | 1 | Illegal template dropped, one-cycle pulse |
| m_rdy | input | NPORT | Memory ports ready |
| m_vld | output | NPORT | Memory port operation valid |
| m_op | output | NPORT x 41 | Memory port payload |
| i_rdy | input | NPORT | Integer ports ready |
| i_vld | output | NPORT | Integer port operation valid |
| i_op | output | NPORT x 41 | Integer port payload |
| f_rdy | input | NPORT | Floating-point ports ready |
| f_vld | output | NPORT | Floating-point port operation valid |
| f_op | output | NPORT x 41 | Floating-point port payload |
| b_rdy | input | NPORT | Branch ports ready |
| b_vld | output | NPORT | Branch port operation valid |
| b_op | output | NPORT x 41 | Branch port payload |

## Verification
The assertions check four things on every cycle. No port is valid without its ready. The ports of a class fill from port 0 upward. The window never holds a younger bundle without an older one, and its head stays inside a bundle. An error pulse only ever follows an accepted bundle. The bench scenarios are needed for everything else. They show that each template decodes to the right classes and stops, and that a mid-bundle stop splits issue over two cycles. They show that a stop-free bundle waits for its successor and then issues six operations at once, and that one missing ready holds back the whole group. They also show that an illegal bundle leaves no trace beyond the error pulse.

// File: rtl/bib_pkg.sv
package bib_pkg;
  localparam int OPW  = 41;
  localparam int NSLT = 3;
  localparam int TMW  = 5;
  localparam int BW   = TMW + NSLT * OPW;
  localparam int NCLS = 4;
  localparam int NPAT = 6;

  typedef enum logic [1:0] {U_MEM = 2'd0, U_INT = 2'd1, U_FP = 2'd2, U_BR = 2'd3} unit_e;

  typedef struct packed {
    unit_e            ut;
    logic             stop;
    logic             nop;
    logic [OPW-1:0]   op;
  } slot_t;

  function automatic logic tmpl_legal(input logic [TMW-1:0] t);
    return int'(t[4:2]) < NPAT;
  endfunction

  function automatic unit_e slot_unit(input logic [2:0] pat, input int s);
    unit_e u;
    u = U_MEM;
    if (s == 1) begin
      case (pat)
        3'd1, 3'd3: u = U_MEM;
        3'd2:       u = U_FP;
        3'd5:       u = U_BR;
        default:    u = U_INT;
      endcase
    end else if (s == 2) begin
      case (pat)
        3'd3:       u = U_FP;
        3'd4, 3'd5: u = U_BR;
        default:    u = U_INT;
      endcase
    end
    return u;
  endfunction

  function automatic logic slot_stop(input logic [1:0] mode, input int s);
    case (mode)
      2'd1:    return s == 2;
      2'd2:    return (s == 0) || (s == 2);
      2'd3:    return (s == 1) || (s == 2);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bib_tmpl_dec.sv
module bib_tmpl_dec
  import bib_pkg::*;
(
  input  logic [BW-1:0]        bundle,
  output logic                 legal,
  output slot_t [NSLT-1:0]     slots
);
  logic [TMW-1:0] tm;
  assign tm    = bundle[TMW-1:0];
  assign legal = tmpl_legal(tm);

  for (genvar s = 0; s < NSLT; s++) begin : g_slot
    assign slots[s].ut   = slot_unit(tm[4:2], s);
    assign slots[s].stop = slot_stop(tm[1:0], s);
    assign slots[s].op   = bundle[TMW + OPW*s +: OPW];
    assign slots[s].nop  = (bundle[TMW + OPW*s +: OPW] == '0);
  end
endmodule

// File: rtl/bib_window.sv
module bib_window
  import bib_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_legal,
  input  slot_t [NSLT-1:0]       in_slots,
  input  logic                   fire,
  input  logic [2:0]             grp_end,
  output slot_t [2*NSLT-1:0]     win,
  output logic                   v0,
  output logic                   v1,
  output logic [1:0]             hp,
  output logic                   in_ready
);
  slot_t [NSLT-1:0] b0, b1, nb0, nb1;
  logic             nv0, nv1, acc, ld_en;
  logic [1:0]       nhp;

  assign in_ready = !v1;
  assign acc      = in_valid && in_ready && in_legal;
  assign ld_en    = acc || fire;
  assign win      = {b1, b0};

  always_comb begin
    nb0 = b0;
    nb1 = b1;
    nv0 = v0;
    nv1 = v1;
    nhp = hp;
    if (fire) begin
      if (grp_end >= 3'd2) begin
        nb0 = b1;
        nv0 = v1 && (grp_end != 3'd5);
        nv1 = 1'b0;
        nhp = (grp_end == 3'd3) ? 2'd1 : (grp_end == 3'd4) ? 2'd2 : 2'd0;
      end else begin
        nhp = grp_end[1:0] + 2'd1;
      end
    end
    if (acc) begin
      if (!nv0) begin
        nb0 = in_slots;
        nv0 = 1'b1;
      end else begin
        nb1 = in_slots;
        nv1 = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0 <= 1'b0;
      v1 <= 1'b0;
      hp <= 2'd0;
    end else begin
      v0 <= nv0;
      v1 <= nv1;
      hp <= nhp;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      b0 <= nb0;
      b1 <= nb1;
    end
  end

  // R8
  win_order_chk: assert property (@(posedge clk) disable iff (!rst_n) v1 |-> v0);
  // R4
  hp_range_chk: assert property (@(posedge clk) disable iff (!rst_n) hp <= 2'd2);
endmodule

// File: rtl/bib_group.sv
module bib_group
  import bib_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  slot_t [2*NSLT-1:0]                       win,
  input  logic                                     v0,
  input  logic                                     v1,
  input  logic [1:0]                               hp,
  input  logic [NCLS-1:0][NPORT-1:0]               rdy,
  output logic                                     fire,
  output logic [2:0]                               grp_end,
  output logic [NCLS-1:0][NPORT-1:0]               pvld,
  output logic [NCLS-1:0][NPORT-1:0][OPW-1:0]      pop
);
  localparam int NWIN = 2 * NSLT;

  logic [NCLS-1:0][NPORT-1:0] need;
  logic                       go, complete, ok;
  int                         avail, u;
  int                         cnt [NCLS];

  always_comb begin
    avail    = v1 ? NWIN : (v0 ? NSLT : 0);
    go       = 1'b1;
    complete = 1'b0;
    ok       = 1'b1;
    grp_end  = 3'd0;
    need     = '0;
    pop      = '0;
    u        = 0;
    for (int c = 0; c < NCLS; c++) cnt[c] = 0;
    for (int p = 0; p < NWIN; p++) begin
      if (go && (p >= int'(hp)) && (p < avail)) begin
        grp_end = 3'(p);
        if (!win[p].nop) begin
          u = int'(win[p].ut);
          if (cnt[u] >= NPORT) ok = 1'b0;
          for (int k = 0; k < NPORT; k++) begin
            if (cnt[u] == k) begin
              need[u][k] = 1'b1;
              pop[u][k]  = win[p].op;
              if (!rdy[u][k]) ok = 1'b0;
            end
          end
          cnt[u] = cnt[u] + 1;
        end
        if (win[p].stop || (p == NWIN-1)) begin
          complete = 1'b1;
          go       = 1'b0;
        end
      end
    end
    fire = v0 && complete && ok;
    pvld = fire ? need : '0;
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    for (genvar k = 0; k < NPORT; k++) begin : g_port
      // R7
      port_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pvld[c][k] |-> rdy[c][k]);
      if (k > 0) begin : g_pre
        // R6
        port_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
          pvld[c][k] |-> pvld[c][k-1]);
      end
    end
  end
endmodule

// File: rtl/bundle_issue.sv
module bundle_issue
  import bib_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [127:0]                in_bundle,
  output logic                        in_ready,
  output logic                        err_o,
  input  logic [NPORT-1:0]            m_rdy,
  output logic [NPORT-1:0]            m_vld,
  output logic [NPORT-1:0][40:0]      m_op,
  input  logic [NPORT-1:0]            i_rdy,
  output logic [NPORT-1:0]            i_vld,
  output logic [NPORT-1:0][40:0]      i_op,
  input  logic [NPORT-1:0]            f_rdy,
  output logic [NPORT-1:0]            f_vld,
  output logic [NPORT-1:0][40:0]      f_op,
  input  logic [NPORT-1:0]            b_rdy,
  output logic [NPORT-1:0]            b_vld,
  output logic [NPORT-1:0][40:0]      b_op
);
  logic [1:0]                           rsync;
  logic                                 rst_s;
  logic                                 legal, fire, v0, v1, err_q, err_d;
  logic [1:0]                           hp;
  logic [2:0]                           grp_end;
  slot_t [NSLT-1:0]                     dslots;
  slot_t [2*NSLT-1:0]                   win;
  logic [NCLS-1:0][NPORT-1:0]           rdy, pvld;
  logic [NCLS-1:0][NPORT-1:0][OPW-1:0]  pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_s = rsync[1];

  bib_tmpl_dec u_dec (
    .bundle (in_bundle),
    .legal  (legal),
    .slots  (dslots)
  );

  bib_window u_win (
    .clk      (clk),
    .rst_n    (rst_s),
    .in_valid (in_valid),
    .in_legal (legal),
    .in_slots (dslots),
    .fire     (fire),
    .grp_end  (grp_end),
    .win      (win),
    .v0       (v0),
    .v1       (v1),
    .hp       (hp),
    .in_ready (in_ready)
  );

  assign rdy = {b_rdy, f_rdy, i_rdy, m_rdy};

  bib_group #(.NPORT(NPORT)) u_grp (
    .clk     (clk),
    .rst_n   (rst_s),
    .win     (win),
    .v0      (v0),
    .v1      (v1),
    .hp      (hp),
    .rdy     (rdy),
    .fire    (fire),
    .grp_end (grp_end),
    .pvld    (pvld),
    .pop     (pop)
  );

  assign m_vld = pvld[U_MEM];
  assign i_vld = pvld[U_INT];
  assign f_vld = pvld[U_FP];
  assign b_vld = pvld[U_BR];
  assign m_op  = pop[U_MEM];
  assign i_op  = pop[U_INT];
  assign f_op  = pop[U_FP];
  assign b_op  = pop[U_BR];

  assign err_d = in_valid && in_ready && !legal;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign err_o = err_q;

  // R2
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_s)
    err_q |-> $past(in_valid && in_ready));
endmodule

// File: tb/bundle_issue_bench.sv
module bundle_issue_bench;
  localparam int NP = 2;

  typedef struct packed {
    logic [4:0]  tm;
    logic [40:0] s0, s1, s2;
    logic [1:0]  em, ei, ef, eb;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{5'd1,  41'h101, 41'h102, 41'h103, 2'b01, 2'b11, 2'b00, 2'b00},
    '{5'd5,  41'h201, 41'h202, 41'h203, 2'b11, 2'b01, 2'b00, 2'b00},
    '{5'd9,  41'h301, 41'h302, 41'h303, 2'b01, 2'b01, 2'b01, 2'b00},
    '{5'd13, 41'h401, 41'h402, 41'h403, 2'b11, 2'b00, 2'b01, 2'b00},
    '{5'd17, 41'h501, 41'h502, 41'h503, 2'b01, 2'b01, 2'b00, 2'b01},
    '{5'd21, 41'h601, 41'h602, 41'h603, 2'b01, 2'b00, 2'b00, 2'b11},
    '{5'd1,  41'h701, 41'h000, 41'h703, 2'b01, 2'b01, 2'b00, 2'b00}
  };

  logic clk, rst_n, in_valid, in_ready, err_o;
  logic [127:0] in_bundle;
  logic [NP-1:0] m_rdy, i_rdy, f_rdy, b_rdy, m_vld, i_vld, f_vld, b_vld;
  logic [NP-1:0][40:0] m_op, i_op, f_op, b_op;
  int checks, fails;
  logic done;

  bundle_issue #(.NPORT(NP)) u_bundle_issue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bundle(in_bundle),
    .in_ready(in_ready), .err_o(err_o),
    .m_rdy(m_rdy), .m_vld(m_vld), .m_op(m_op),
    .i_rdy(i_rdy), .i_vld(i_vld), .i_op(i_op),
    .f_rdy(f_rdy), .f_vld(f_vld), .f_op(f_op),
    .b_rdy(b_rdy), .b_vld(b_vld), .b_op(b_op)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] tm, input logic [40:0] s0, input logic [40:0] s1,
                      input logic [40:0] s2);
    @(negedge clk);
    in_valid  = 1'b1;
    in_bundle = {s2, s1, s0, tm};
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_vld(input string req, input logic [1:0] em, input logic [1:0] ei,
                         input logic [1:0] ef, input logic [1:0] eb);
    chk({req, " mem"}, 64'(m_vld), 64'(em));
    chk({req, " int"}, 64'(i_vld), 64'(ei));
    chk({req, " fp"},  64'(f_vld), 64'(ef));
    chk({req, " br"},  64'(b_vld), 64'(eb));
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_bundle = '0;
    m_rdy = '1; i_rdy = '1; f_rdy = '1; b_rdy = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R9 reset state
    chk_vld("R9", 2'b00, 2'b00, 2'b00, 2'b00);
    chk("R9 err", 64'(err_o), 64'd0);
    chk("R9 in_ready", 64'(in_ready), 64'd1);

    // R1 R3 R5 R6 table of templates
    for (int n = 0; n < 7; n++) begin
      push(VECS[n].tm, VECS[n].s0, VECS[n].s1, VECS[n].s2);
      chk_vld("R1 R3 vector", VECS[n].em, VECS[n].ei, VECS[n].ef, VECS[n].eb);
      chk("R6 payload m0", 64'(m_op[0]), 64'(VECS[n].s0));
      if (n == 6) chk("R5 nop skipped i0", 64'(i_op[0]), 64'(VECS[n].s2));
      step();
    end

    // R2 illegal template dropped
    push(5'd24, 41'h801, 41'h802, 41'h803);
    chk("R2 err pulse", 64'(err_o), 64'd1);
    chk_vld("R2 no issue", 2'b00, 2'b00, 2'b00, 2'b00);
    step();
    chk("R2 err clears", 64'(err_o), 64'd0);
    chk_vld("R2 still empty", 2'b00, 2'b00, 2'b00, 2'b00);
    chk("R2 in_ready", 64'(in_ready), 64'd1);

    // R3 mid-bundle stop after slot 0
    push(5'd2, 41'h901, 41'h902, 41'h903);
    chk_vld("R3 first group", 2'b01, 2'b00, 2'b00, 2'b00);
    step();
    chk_vld("R3 second group", 2'b00, 2'b11, 2'b00, 2'b00);
    chk("R6 payload i1", 64'(i_op[1]), 64'h903);
    step();

    // R4 group spanning two bundles
    push(5'd0, 41'hA01, 41'hA02, 41'hA03);
    chk_vld("R4 waits for next bundle", 2'b00, 2'b00, 2'b00, 2'b00);
    push(5'd21, 41'hB01, 41'hB02, 41'hB03);
    chk_vld("R4 six wide", 2'b11, 2'b11, 2'b00, 2'b11);
    chk("R6 payload m1", 64'(m_op[1]), 64'hB01);
    chk("R6 payload b1", 64'(b_op[1]), 64'hB03);
    step();
    chk_vld("R4 drained", 2'b00, 2'b00, 2'b00, 2'b00);

    // R7 whole group stalls on one missing ready
    i_rdy = 2'b01;
    push(5'd1, 41'hC01, 41'hC02, 41'hC03);
    chk_vld("R7 stalled", 2'b00, 2'b00, 2'b00, 2'b00);
    i_rdy = 2'b11;
    #1;
    chk_vld("R7 released", 2'b01, 2'b11, 2'b00, 2'b00);
    step();

    // R8 window full
    i_rdy = 2'b00;
    push(5'd1, 41'hD01, 41'hD02, 41'hD03);
    chk("R8 one held", 64'(in_ready), 64'd1);
    push(5'd1, 41'hE01, 41'hE02, 41'hE03);
    chk("R8 full", 64'(in_ready), 64'd0);
    i_rdy = 2'b11;
    #1;
    chk("R7 order older first", 64'(i_op[0]), 64'hD02);
    step();
    chk("R8 space again", 64'(in_ready), 64'd1);
    chk("R7 order younger next", 64'(i_op[0]), 64'hE02);
    step();
    chk_vld("R8 empty", 2'b00, 2'b00, 2'b00, 2'b00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule